// File: doc/BRIEF.md
# Cutoff Table Entry Generator

This block turns a scaled squared pair distance into a read address for two small host-loaded tables and returns what both tables hold at that address. The input is the base-2 logarithm of r²/η², carried in a 15-bit fixed-point field with 8 fractional bits, plus a flag that marks the value as non-zero. One table holds the reciprocal of the force cutoff function and the other holds the reciprocal of the potential cutoff function. Each word is a 12-bit logarithm with 4 integer bits and 8 fractional bits.

The address is built in two steps that behave as one. First, the logarithm of the squared distance becomes a linear distance index B = round(128 · 2^(A/512)), so one step of B is 1/128 of r/η. Second, B is folded into 8 bits. Resolution is full up to r/η = 1.5, halved up to 2.0, quartered up to 3.0, and the address saturates beyond that. This spends table entries where the cutoff changes fastest. A lookup takes two clock cycles and can start on every cycle. The host fills the tables through a separate write port before the computation starts.

Top module: `cutoff_entry_gen`

## Requirements
- R1: While reset is held and right after it, `outValid` is low and both `forceRecip` and `potRecip` read zero.
- R2: The input field A is a signed two's-complement number. The linear index is B = round-half-up(128 · 2^(A/512)), clamped to 0..511. Any A below −4096 gives B = 0, and with it address 0.
- R3: For B in 0..191 the table address is B[7:0].
- R4: For B in 192..255 the table address is binary 110 followed by B[5:1].
- R5: For B in 256..383 the table address is binary 111 followed by B[6:2].
- R6: For B of 384 or more, which includes every clamped value, the table address is 8'hFF.
- R7: When `logNonZero` is low, the address is 0 whatever the value of A.
- R8: `outValid` is high exactly two cycles after each cycle in which `inValid` is high, and low otherwise. Lookups may arrive on back-to-back cycles.
- R9: When no lookup completes in a cycle, `forceRecip` and `potRecip` keep their previous values, even if the lookup inputs change.
- R10: A host write with `wrEn` high stores `wrData` at `wrAddr` in the force table when `wrSel` is 0 and in the potential table when `wrSel` is 1. The other table is left unchanged. A later lookup of that address returns the new word on the selected output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Starts a lookup with the current `logIn` and `logNonZero` |
| logIn | input | 15 | Signed log2(r²/η²), 8 fractional bits |
| logNonZero | input | 1 | High when the distance value is non-zero |
| wrEn | input | 1 | Host table write strobe |
| wrSel | input | 1 | Table select for the write: 0 force, 1 potential |
| wrAddr | input | 8 | Table address for the write |
| wrData | input | 12 | Word to store (4.8 log format) |
| outValid | output | 1 | Marks the cycle in which the lookup result appears |
| forceRecip | output | 12 | Force table word at the looked-up address |
| potRecip | output | 12 | Potential table word at the looked-up address |

## Verification
The hardest cases to reach from the ports are the edges between the address segments and the round-half-up tie in the exponential step. They sit on a few exact values of A, such as the one that gives B = 0.5 and the ones just below and above r/η = 1.5, 2.0 and 3.0. The tables are loaded with a distinct word per address, so each output reveals the address that was used. The stimulus table then steps A across those exact edge values with both signs, at both extremes of the field, and with the non-zero flag cleared. Directed sequences cover back-to-back lookups, idle cycles with changing inputs, and host rewrites of single entries.

// File: rtl/cte_pkg.sv
package cte_pkg;

  // Per-cycle strobes from the control half to the datapath half.
  typedef struct packed {
    logic capture;  // load the computed address into stage 1
    logic readEn;   // read both tables into the output registers
    logic wrForce;  // host write into the force table
    logic wrPot;    // host write into the potential table
  } cte_strobe_t;

endpackage

// File: rtl/cte_ctrl.sv
module cte_ctrl
  import cte_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        wrEn,
  input  logic        wrSel,
  output cte_strobe_t strobe,
  output logic        outValid
);

  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.readEn  = stage1Valid;
    strobe.wrForce = wrEn & ~wrSel;
    strobe.wrPot   = wrEn & wrSel;
  end

  assign outValid = stage2Valid;

  // R8: a lookup request shows up as a result strobe two cycles later
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> ##1 outValid);

  // R8: no result strobe without a request two cycles earlier
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ##1 !outValid);

endmodule

// File: rtl/cte_datapath.sv
module cte_datapath
  import cte_pkg::*;
#(
  parameter int LOG_W       = 15,
  parameter int LOG_FRAC    = 8,
  parameter int B_W         = 9,
  parameter int B_SCALE_LOG = 7,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 12,
  parameter int MANT_FRAC   = 24,
  parameter int N_TABLES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cte_strobe_t       strobe,
  input  logic [LOG_W-1:0]  logIn,
  input  logic              logNonZero,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] forceRecip,
  output logic [DATA_W-1:0] potRecip
);

  // Square root in the log domain: one extra fractional bit.
  localparam int HS       = LOG_FRAC + 1;
  localparam int SEG      = 1 << HS;
  localparam int KW       = LOG_W - HS;
  localparam int MW       = MANT_FRAC + 1;
  localparam int SUMW     = MW + 2;
  localparam int B_MAX    = (1 << B_W) - 1;
  localparam int DEPTH    = 1 << ADDR_W;
  // Segment edges of the linear index.
  localparam int EDGE_HALF  = 3 * (1 << (B_W - 3));
  localparam int EDGE_QUART = 1 << (B_W - 1);
  localparam int EDGE_SAT   = 3 * (1 << (B_W - 2));

  // Constant function: 2^(idx/SEG) in fixed point with MANT_FRAC fraction bits.
  function automatic logic [MW-1:0] mantVal(input int idx);
    real v;
    v = 2.0 ** (real'(idx) / real'(SEG));
    return MW'($rtoi(v * (2.0 ** MANT_FRAC) + 0.5));
  endfunction

  logic [MW-1:0] mantTab [SEG];

  for (genvar g = 0; g < SEG; g++) begin : g_mant
    localparam logic [MW-1:0] MantEntry = mantVal(g);
    assign mantTab[g] = MantEntry;
  end

  // ---------------- stage 0: log to linear index ----------------
  logic signed [KW-1:0] kExp;
  logic [HS-1:0]        fracIdx;
  logic [MW-1:0]        mant;
  int                   kInt;
  int                   shAmt;
  logic [SUMW-1:0]      halfBit;
  logic [SUMW-1:0]      roundSum;
  logic [SUMW-1:0]      wideIdx;
  logic [B_W-1:0]       linIdx;

  assign kExp    = logIn[LOG_W-1:HS];
  assign fracIdx = logIn[HS-1:0];
  assign mant    = mantTab[fracIdx];

  always_comb begin
    kInt     = int'(kExp);
    shAmt    = MANT_FRAC - B_SCALE_LOG - kInt;
    halfBit  = '0;
    roundSum = '0;
    wideIdx  = '0;
    if (kInt + B_SCALE_LOG >= B_W) begin
      linIdx = B_W'(B_MAX);
    end else if (shAmt > MW) begin
      linIdx = '0;
    end else begin
      halfBit  = SUMW'(1) << (shAmt - 1);
      roundSum = SUMW'(mant) + halfBit;
      wideIdx  = roundSum >> shAmt;
      if (wideIdx > SUMW'(B_MAX)) linIdx = B_W'(B_MAX);
      else                        linIdx = wideIdx[B_W-1:0];
    end
  end

  // ---------------- stage 0: index compression ----------------
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    if (!logNonZero) begin
      nextAddr = '0;
    end else if (int'(linIdx) < EDGE_HALF) begin
      nextAddr = linIdx[ADDR_W-1:0];
    end else if (int'(linIdx) < EDGE_QUART) begin
      nextAddr = {3'b110, linIdx[ADDR_W-3:1]};
    end else if (int'(linIdx) < EDGE_SAT) begin
      nextAddr = {3'b111, linIdx[ADDR_W-2:2]};
    end else begin
      nextAddr = '1;
    end
  end

  // ---------------- stage 1: address register ----------------
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (!rst_n)              addrQ <= '0;
    else if (strobe.capture) addrQ <= nextAddr;
  end

  // ---------------- stage 2: tables ----------------
  logic [DATA_W-1:0] rdData [N_TABLES];

  for (genvar t = 0; t < N_TABLES; t++) begin : g_tab
    logic [DATA_W-1:0] mem [DEPTH];
    logic              weT;

    assign weT = (t == 0) ? strobe.wrForce : strobe.wrPot;

    always_ff @(posedge clk) begin
      if (weT) mem[wrAddr] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)             rdData[t] <= '0;
      else if (strobe.readEn) rdData[t] <= mem[addrQ];
    end
  end

  assign forceRecip = rdData[0];
  assign potRecip   = rdData[N_TABLES-1];

  // R6: r/eta of 3.0 or more (A >= 812) always lands on the last entry
  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && logNonZero && ($signed(logIn) >= 15'sd812)) |=> (addrQ == '1));

  // R7: a zero distance always selects entry 0
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && !logNonZero) |=> (addrQ == '0));

  // R2: very small distances round to index 0
  p_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && logNonZero && ($signed(logIn) < -15'sd4200)) |=> (addrQ == '0));

  // R9: outputs hold when no read completes
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.readEn |=> ($stable(forceRecip) && $stable(potRecip)));

endmodule

// File: rtl/cutoff_entry_gen.sv
module cutoff_entry_gen
  import cte_pkg::*;
#(
  parameter int LOG_W     = 15,
  parameter int LOG_FRAC  = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 12,
  parameter int MANT_FRAC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [LOG_W-1:0]  logIn,
  input  logic              logNonZero,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              outValid,
  output logic [DATA_W-1:0] forceRecip,
  output logic [DATA_W-1:0] potRecip
);

  localparam int B_W = ADDR_W + 1;

  cte_strobe_t strobe;

  cte_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  cte_datapath #(
    .LOG_W       (LOG_W),
    .LOG_FRAC    (LOG_FRAC),
    .B_W         (B_W),
    .B_SCALE_LOG (7),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .MANT_FRAC   (MANT_FRAC),
    .N_TABLES    (2)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .logIn      (logIn),
    .logNonZero (logNonZero),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .forceRecip (forceRecip),
    .potRecip   (potRecip)
  );

endmodule

// File: tb/sim_cutoff_entry_gen.sv
`timescale 1ns/1ps
module sim_cutoff_entry_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inValid;
  logic [14:0] logIn;
  logic        logNonZero;
  logic        wrEn;
  logic        wrSel;
  logic [7:0]  wrAddr;
  logic [11:0] wrData;
  logic        outValid;
  logic [11:0] forceRecip;
  logic [11:0] potRecip;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  cutoff_entry_gen u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .logIn(logIn),
    .logNonZero(logNonZero), .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr),
    .wrData(wrData), .outValid(outValid), .forceRecip(forceRecip),
    .potRecip(potRecip)
  );

  // {nonzero flag, signed A}
  localparam int NV = 22;
  localparam logic [15:0] VECS [NV] = '{
    {1'b1, 15'sd0},      {1'b1, -15'sd512},   {1'b1, -15'sd1024},
    {1'b1, -15'sd4096},  {1'b1, -15'sd4097},  {1'b1, -15'sd5000},
    {1'b1, -15'sd16384}, {1'b1, 15'sd200},    {1'b1, 15'sd290},
    {1'b1, 15'sd300},    {1'b1, 15'sd400},    {1'b1, 15'sd511},
    {1'b1, 15'sd512},    {1'b1, 15'sd600},    {1'b1, 15'sd800},
    {1'b1, 15'sd810},    {1'b1, 15'sd811},    {1'b1, 15'sd1024},
    {1'b1, 15'sd16383},  {1'b0, 15'sd100},    {1'b0, 15'sd16383},
    {1'b0, -15'sd3000}
  };

  function automatic int forceWord(int a);
    return (a ^ 12'h5A0) & 12'hFFF;
  endfunction

  function automatic int potWord(int a);
    return (a * 5 + 17) & 12'hFFF;
  endfunction

  function automatic int modelIdx(logic signed [14:0] a);
    real x;
    x = 2.0 ** (7.0 + real'(a) / 512.0);
    if (x >= 511.5) return 511;
    return $rtoi(x + 0.5);
  endfunction

  function automatic int modelAddr(logic signed [14:0] a, logic nz);
    int b;
    if (!nz) return 0;
    b = modelIdx(a);
    if (b < 192) return b;
    if (b < 256) return 8'hC0 | ((b >> 1) & 8'h1F);
    if (b < 384) return 8'hE0 | ((b >> 2) & 8'h1F);
    return 8'hFF;
  endfunction

  function automatic string tagFor(logic signed [14:0] a, logic nz);
    int b;
    if (!nz) return "R7";
    b = modelIdx(a);
    if (b == 0) return "R2";
    if (b < 192) return "R3";
    if (b < 256) return "R4";
    if (b < 384) return "R5";
    return "R6";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input bit sel, input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrAddr = 8'(a); wrData = 12'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // One isolated lookup; checks strobe timing and both words.
  task automatic lookup(input logic signed [14:0] a, input logic nz,
                        input int expF, input int expP, input string req);
    @(negedge clk);
    inValid = 1'b1; logIn = a; logNonZero = nz;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b0, "R8", "early strobe", int'(outValid), 0);
    @(negedge clk);
    chk(outValid == 1'b1, "R8", "strobe", int'(outValid), 1);
    chk(int'(forceRecip) == expF, req, "force word", int'(forceRecip), expF);
    chk(int'(potRecip) == expP, req, "pot word", int'(potRecip), expP);
    @(negedge clk);
    chk(outValid == 1'b0, "R8", "strobe drop", int'(outValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int adr;
    rst_n = 1'b0; inValid = 1'b0; logIn = '0; logNonZero = 1'b0;
    wrEn = 1'b0; wrSel = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    chk(forceRecip == 12'd0, "R1", "force in reset", int'(forceRecip), 0);
    chk(potRecip == 12'd0, "R1", "pot in reset", int'(potRecip), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0 && forceRecip == 12'd0 && potRecip == 12'd0,
        "R1", "after reset", int'(outValid), 0);

    // R10: fill both tables with distinct words
    for (int a = 0; a < 256; a++) hostWrite(1'b0, a, forceWord(a));
    for (int a = 0; a < 256; a++) hostWrite(1'b1, a, potWord(a));

    // Vector walk: R2..R7
    for (int i = 0; i < NV; i++) begin
      adr = modelAddr(VECS[i][14:0], VECS[i][15]);
      lookup(VECS[i][14:0], VECS[i][15], forceWord(adr), potWord(adr),
             tagFor(VECS[i][14:0], VECS[i][15]));
    end

    // Exact hand-derived addresses: R3 A=0 -> 128, R4 A=300 -> C0, R5 A=512 -> E0
    lookup(15'sd0, 1'b1, forceWord(128), potWord(128), "R3");
    lookup(15'sd300, 1'b1, forceWord(8'hC0), potWord(8'hC0), "R4");
    lookup(15'sd512, 1'b1, forceWord(8'hE0), potWord(8'hE0), "R5");
    // R2: tie at B = 0.5 rounds up to 1
    lookup(-15'sd4096, 1'b1, forceWord(1), potWord(1), "R2");

    // R8: back-to-back lookups
    @(negedge clk); inValid = 1'b1; logIn = 15'sd0;    logNonZero = 1'b1;
    @(negedge clk); logIn = -15'sd512;
    @(negedge clk); logIn = 15'sd900;
    chk(outValid && forceRecip == 12'(forceWord(128)), "R8", "burst 0",
        int'(forceRecip), forceWord(128));
    @(negedge clk); inValid = 1'b0;
    chk(outValid && forceRecip == 12'(forceWord(64)), "R8", "burst 1",
        int'(forceRecip), forceWord(64));
    @(negedge clk);
    chk(outValid && potRecip == 12'(potWord(255)), "R8", "burst 2",
        int'(potRecip), potWord(255));
    @(negedge clk);
    chk(outValid == 1'b0, "R8", "burst end", int'(outValid), 0);

    // R9: idle with changing inputs, outputs hold
    logIn = 15'sd0; logNonZero = 1'b0;
    @(negedge clk); logIn = -15'sd1024; logNonZero = 1'b1;
    @(negedge clk);
    chk(forceRecip == 12'(forceWord(255)) && potRecip == 12'(potWord(255)),
        "R9", "hold while idle", int'(forceRecip), forceWord(255));

    // R10: rewrite force[64], potential must not change
    hostWrite(1'b0, 64, 12'hABC);
    lookup(-15'sd512, 1'b1, 12'hABC, potWord(64), "R10");
    hostWrite(1'b1, 64, 12'h123);
    lookup(-15'sd512, 1'b1, 12'hABC, 12'h123, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule